// File: doc/BRIEF.md
# DRAM Idle Low-Power Sequencer

This block sits beside a memory controller and runs on the controller's DFI clock, which is half the DRAM clock rate. It counts consecutive cycles in which the bus carries no request. As the idle time grows it moves the DRAM into deeper low-power states. The shallowest state is power-down. Next comes self-refresh, then self-refresh with the controller clock gated, then (only for LPDDR4 parts) a lite self-refresh power-down, and last a full standby in which the controller, PHY and DRAM clocks are all gated.

Each memory-side state change uses a four-phase request/acknowledge handshake with the command logic. That command logic issues the actual power-down and self-refresh commands and lies outside this block. Any bus request clears the idle count. It unwinds the current state one layer at a time, and the bus is told to wait (`bus_rdy` low) until the unwind is complete. The thresholds come from configuration registers. A threshold of zero switches its mode off, so configuration registers that reset to zero leave every mode disabled.

Top module: `dram_lp_seq`

## Requirements
- R1: The idle count is the number of consecutive clock edges at which `bus_req` was low. Any edge with `bus_req` high restarts it from zero. From the active state, `pd_req` is first high after `pd_idle_thr`+1 idle edges when no deeper mode is reached by then.
- R2: The self-refresh, gated self-refresh and lite thresholds are scaled by 2^`SCALE_LOG2` idle cycles (1024 by default). From the active state, `sr_req` is first high after `sr_idle_thr`·2^`SCALE_LOG2`+1 idle edges.
- R3: A threshold of zero disables its mode. With every threshold zero, no request and no clock gate ever rises, and `bus_rdy` stays high.
- R4: When several thresholds are reached at once, the deepest enabled mode is entered directly. `pd_req` and `sr_req` are never high together. Going from power-down to self-refresh first completes the power-down exit (`pd_req` low, `pd_ack` low) and spends one cycle in the active state.
- R5: In self-refresh, `cg_ctrl` rises once the idle count reaches `srcg_idle_thr`·2^`SCALE_LOG2`. `cg_ctrl` is the controller clock-gate enable, and 1 means gated.
- R6: The lite mode (`lite_req`) is entered from self-refresh when its scaled threshold is reached, and only when `type_lp4` is 1. It keeps `cg_ctrl` set. When `type_lp4` is 0, the lite threshold has no effect.
- R7: Standby sets `cg_ctrl`, `cg_phy` and `cg_dram` once the idle count reaches `stby_idle_thr`, which is counted in unscaled cycles. When the sequencer is in lite mode, it first drops `lite_req` and waits for `lite_ack` low before gating.
- R8: A clock-gate enable is high only while both `sr_req` and `sr_ack` are high. All gates are low during the cycle before `sr_req` falls.
- R9: A bus request blocks any new entry. `bus_rdy` is high only in the active state. With a one-cycle acknowledge, `bus_rdy` returns 3 edges after the request when leaving power-down or ungated self-refresh, 4 when leaving gated self-refresh or standby, and 7 when leaving lite mode.
- R10: After reset, all requests and gates are low and `bus_rdy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DFI-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Bus has a pending request (not idle) |
| type_lp4 | input | 1 | Attached DRAM is LPDDR4 |
| pd_idle_thr | input | PD_W | Power-down threshold, in cycles, 0 = off |
| sr_idle_thr | input | THR_W | Self-refresh threshold, scaled, 0 = off |
| srcg_idle_thr | input | THR_W | Gated self-refresh threshold, scaled, 0 = off |
| lite_idle_thr | input | THR_W | Lite power-down threshold, scaled, 0 = off |
| stby_idle_thr | input | STBY_W | Standby threshold, in cycles, 0 = off |
| pd_req | output | 1 | Power-down request (high = enter, low = exit) |
| pd_ack | input | 1 | Power-down acknowledge, follows `pd_req` |
| sr_req | output | 1 | Self-refresh request |
| sr_ack | input | 1 | Self-refresh acknowledge |
| lite_req | output | 1 | Lite power-down request |
| lite_ack | input | 1 | Lite power-down acknowledge |
| cg_ctrl | output | 1 | Gate controller clock |
| cg_phy | output | 1 | Gate PHY clock |
| cg_dram | output | 1 | Gate DRAM clock |
| bus_rdy | output | 1 | Bus may proceed (active state) |

## Verification
The assertions check the safety rules on every cycle: gates appear only inside an acknowledged self-refresh, and they are dropped before its exit. The two main requests are never high together. The lite mode is tied to the LPDDR4 type, and standby never overlaps it. No entry starts in a cycle that follows bus activity. The exact cycle of each entry can only be shown by the bench's scenarios, which sweep the thresholds on a small configuration. Those scenarios also cover the 2^N scaling, the choice of the deepest mode, the restart of the count by a single busy cycle, and the wake-up latency from each state.

// File: rtl/dram_lp_pkg.sv
package dram_lp_pkg;

   // Power depth, ordered shallow to deep; the FSM compares these by magnitude.
   typedef enum logic [2:0] {
      D_ACT  = 3'd0,
      D_PD   = 3'd1,
      D_SR   = 3'd2,
      D_SRCG = 3'd3,
      D_LITE = 3'd4,
      D_STBY = 3'd5
   } lp_depth_e;

   typedef enum logic [3:0] {
      S_ACT, S_PD_IN, S_PD, S_PD_OUT,
      S_SR_IN, S_SR, S_LT_IN, S_LT, S_LT_OUT, S_SR_OUT
   } lp_state_e;

endpackage

// File: rtl/dram_lp_idle_timer.sv
module dram_lp_idle_timer #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy,
   output logic [CW-1:0] cnt
);
   if (CW < 2) begin : g_bad_cw
      $error("dram_lp_idle_timer: CW must be at least 2");
   end

   // Saturating count of consecutive idle edges.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (busy)   cnt <= '0;
      else if (!(&cnt)) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/dram_lp_thr_cmp.sv
module dram_lp_thr_cmp #(
   parameter int TW    = 8,
   parameter int CW    = 12,
   parameter int SHIFT = 0
) (
   input  logic [TW-1:0] thr,
   input  logic [CW-1:0] cnt,
   output logic          hit
);
   if (TW + SHIFT >= CW) begin : g_bad_w
      $error("dram_lp_thr_cmp: scaled threshold does not fit the counter");
   end

   logic [CW-1:0] lim;
   assign lim = CW'(thr) << SHIFT;
   assign hit = (thr != '0) && (cnt >= lim);
endmodule

// File: rtl/dram_lp_depth_pick.sv
module dram_lp_depth_pick
   import dram_lp_pkg::*;
(
   input  logic      busy,
   input  logic      lp4,
   input  logic      hit_pd,
   input  logic      hit_sr,
   input  logic      hit_srcg,
   input  logic      hit_lite,
   input  logic      hit_stby,
   output lp_depth_e depth
);
   // Later assignments are deeper, so the deepest reached mode wins.
   always_comb begin
      depth = D_ACT;
      if (!busy) begin
         if (hit_pd)          depth = D_PD;
         if (hit_sr)          depth = D_SR;
         if (hit_srcg)        depth = D_SRCG;
         if (hit_lite && lp4) depth = D_LITE;
         if (hit_stby)        depth = D_STBY;
      end
   end
endmodule

// File: rtl/dram_lp_seq.sv
module dram_lp_seq
   import dram_lp_pkg::*;
#(
   parameter int PD_W       = 8,
   parameter int THR_W      = 8,
   parameter int STBY_W     = 16,
   parameter int SCALE_LOG2 = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              type_lp4,
   input  logic [PD_W-1:0]   pd_idle_thr,
   input  logic [THR_W-1:0]  sr_idle_thr,
   input  logic [THR_W-1:0]  srcg_idle_thr,
   input  logic [THR_W-1:0]  lite_idle_thr,
   input  logic [STBY_W-1:0] stby_idle_thr,
   output logic              pd_req,
   input  logic              pd_ack,
   output logic              sr_req,
   input  logic              sr_ack,
   output logic              lite_req,
   input  logic              lite_ack,
   output logic              cg_ctrl,
   output logic              cg_phy,
   output logic              cg_dram,
   output logic              bus_rdy
);
   localparam int SC_W   = THR_W + SCALE_LOG2;
   localparam int DIR_W  = (PD_W > STBY_W) ? PD_W : STBY_W;
   localparam int CW     = ((DIR_W > SC_W) ? DIR_W : SC_W) + 1;
   localparam int N_SC   = 3;

   if (PD_W < 1 || THR_W < 1 || STBY_W < 1) begin : g_bad_w
      $error("dram_lp_seq: threshold widths must be positive");
   end
   if (SCALE_LOG2 < 0 || SCALE_LOG2 > 20) begin : g_bad_sc
      $error("dram_lp_seq: SCALE_LOG2 out of range");
   end

   logic [CW-1:0]    idle_cnt;
   logic [THR_W-1:0] sc_thr [N_SC];
   logic [N_SC-1:0]  sc_hit;
   logic             hit_pd, hit_stby;
   lp_depth_e        tgt;
   lp_state_e        st;
   logic             far_gate;
   logic             any_gate;

   dram_lp_idle_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .busy(bus_req), .cnt(idle_cnt));

   dram_lp_thr_cmp #(.TW(PD_W), .CW(CW), .SHIFT(0)) u_cmp_pd (
      .thr(pd_idle_thr), .cnt(idle_cnt), .hit(hit_pd));

   dram_lp_thr_cmp #(.TW(STBY_W), .CW(CW), .SHIFT(0)) u_cmp_stby (
      .thr(stby_idle_thr), .cnt(idle_cnt), .hit(hit_stby));

   assign sc_thr[0] = sr_idle_thr;
   assign sc_thr[1] = srcg_idle_thr;
   assign sc_thr[2] = lite_idle_thr;

   for (genvar i = 0; i < N_SC; i++) begin : g_scaled
      dram_lp_thr_cmp #(.TW(THR_W), .CW(CW), .SHIFT(SCALE_LOG2)) u_cmp (
         .thr(sc_thr[i]), .cnt(idle_cnt), .hit(sc_hit[i]));
   end

   dram_lp_depth_pick u_pick (
      .busy(bus_req), .lp4(type_lp4),
      .hit_pd(hit_pd), .hit_sr(sc_hit[0]), .hit_srcg(sc_hit[1]),
      .hit_lite(sc_hit[2]), .hit_stby(hit_stby), .depth(tgt));

   assign any_gate = cg_ctrl | far_gate;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_ACT;
         pd_req   <= 1'b0;
         sr_req   <= 1'b0;
         lite_req <= 1'b0;
         cg_ctrl  <= 1'b0;
         far_gate <= 1'b0;
      end else begin
         unique case (st)
            S_ACT: begin
               if (tgt >= D_SR) begin
                  st     <= S_SR_IN;
                  sr_req <= 1'b1;
               end else if (tgt == D_PD) begin
                  st     <= S_PD_IN;
                  pd_req <= 1'b1;
               end
            end
            S_PD_IN:  if (pd_ack) st <= S_PD;
            S_PD: begin
               if (tgt != D_PD) begin
                  st     <= S_PD_OUT;
                  pd_req <= 1'b0;
               end
            end
            S_PD_OUT: if (!pd_ack) st <= S_ACT;
            S_SR_IN:  if (sr_ack) st <= S_SR;
            S_SR: begin
               // Gates follow the target; a wake drops them one cycle
               // before the self-refresh exit request.
               cg_ctrl  <= (tgt >= D_SRCG);
               far_gate <= (tgt == D_STBY);
               if (tgt == D_LITE) begin
                  st       <= S_LT_IN;
                  lite_req <= 1'b1;
               end else if (bus_req && !any_gate) begin
                  st     <= S_SR_OUT;
                  sr_req <= 1'b0;
               end
            end
            S_LT_IN:  if (lite_ack) st <= S_LT;
            S_LT: begin
               if (tgt != D_LITE) begin
                  st       <= S_LT_OUT;
                  lite_req <= 1'b0;
               end
            end
            S_LT_OUT: if (!lite_ack) st <= S_SR;
            S_SR_OUT: if (!sr_ack) st <= S_ACT;
            default:  st <= S_ACT;
         endcase
      end
   end

   assign cg_phy  = far_gate;
   assign cg_dram = far_gate;
   assign bus_rdy = (st == S_ACT);
endmodule

// File: rtl/dram_lp_seq_chk.sv
module dram_lp_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic bus_req,
   input logic type_lp4,
   input logic pd_req,
   input logic sr_req,
   input logic sr_ack,
   input logic lite_req,
   input logic cg_ctrl,
   input logic cg_phy,
   input logic cg_dram,
   input logic bus_rdy
);
   logic gated;
   assign gated = cg_ctrl | cg_phy | cg_dram;

   p_gate_in_sr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      gated |-> (sr_req && sr_ack));

   p_ungate_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sr_req) |-> (!gated && !$past(gated)));

   p_one_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(pd_req && sr_req));

   p_lite_type_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lite_req) |-> type_lp4);

   p_stby_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cg_phy |-> (cg_ctrl && cg_dram && !lite_req));

   p_no_pd_entry_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_req) |-> !$past(bus_req));

   p_no_sr_entry_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sr_req) |-> !$past(bus_req));

   p_rdy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdy |-> (!pd_req && !sr_req && !lite_req && !gated));
endmodule

bind dram_lp_seq dram_lp_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .type_lp4(type_lp4),
   .pd_req(pd_req), .sr_req(sr_req), .sr_ack(sr_ack), .lite_req(lite_req),
   .cg_ctrl(cg_ctrl), .cg_phy(cg_phy), .cg_dram(cg_dram), .bus_rdy(bus_rdy));

// File: tb/dram_lp_seq_bench.sv
`timescale 1ns/1ps
module dram_lp_seq_bench;
   localparam int PW = 8;
   localparam int TW = 4;
   localparam int BW = 8;
   localparam int SH = 2;
   localparam int SC = 1 << SH;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_req = 1'b1;
   logic lp4 = 1'b0;
   logic [PW-1:0] pd_thr = '0;
   logic [TW-1:0] sr_thr = '0, cg_thr = '0, lt_thr = '0;
   logic [BW-1:0] sb_thr = '0;
   logic pd_req, sr_req, lite_req, cg_ctrl, cg_phy, cg_dram, bus_rdy;
   logic pd_ack, sr_ack, lite_ack;

   always #2.5 clk = ~clk;

   dram_lp_seq #(.PD_W(PW), .THR_W(TW), .STBY_W(BW), .SCALE_LOG2(SH)) u_dram_lp_seq (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .type_lp4(lp4),
      .pd_idle_thr(pd_thr), .sr_idle_thr(sr_thr), .srcg_idle_thr(cg_thr),
      .lite_idle_thr(lt_thr), .stby_idle_thr(sb_thr),
      .pd_req(pd_req), .pd_ack(pd_ack), .sr_req(sr_req), .sr_ack(sr_ack),
      .lite_req(lite_req), .lite_ack(lite_ack),
      .cg_ctrl(cg_ctrl), .cg_phy(cg_phy), .cg_dram(cg_dram), .bus_rdy(bus_rdy));

   // Command-side model: acknowledge follows request one cycle later.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_ack <= 1'b0; sr_ack <= 1'b0; lite_ack <= 1'b0;
      end else begin
         pd_ack <= pd_req; sr_ack <= sr_req; lite_ack <= lite_req;
      end
   end

   int total = 0, bad = 0;
   int n;
   int t_pd, t_pdf, t_sr, t_cg, t_lt, t_sb;
   bit prev_sr = 0, prev_pd = 0;
   bit order_bad = 0;
   bit rdy_dropped = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_marks();
      t_pd = -1; t_pdf = -1; t_sr = -1; t_cg = -1; t_lt = -1; t_sb = -1;
      rdy_dropped = 0;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      n++;
      if (pd_req && t_pd < 0) t_pd = n;
      if (prev_pd && !pd_req && t_pdf < 0) t_pdf = n;
      if (sr_req && t_sr < 0) t_sr = n;
      if (cg_ctrl && t_cg < 0) t_cg = n;
      if (lite_req && t_lt < 0) t_lt = n;
      if (cg_phy && t_sb < 0) t_sb = n;
      if (!bus_rdy) rdy_dropped = 1;
      if (prev_sr && !sr_req && (cg_ctrl || cg_phy || cg_dram)) order_bad = 1;
      if ((cg_ctrl || cg_phy || cg_dram) && !sr_ack) order_bad = 1;
      prev_sr = sr_req;
      prev_pd = pd_req;
   endtask

   task automatic configure(input int p, input int s, input int c, input int l,
                            input int b, input bit f4);
      pd_thr = PW'(p); sr_thr = TW'(s); cg_thr = TW'(c); lt_thr = TW'(l);
      sb_thr = BW'(b); lp4 = f4;
   endtask

   // Idle for a number of edges, then request the bus and time bus_rdy.
   task automatic run(input int idle, output int lat);
      bus_req = 1'b1;
      repeat (3) tick();
      clear_marks();
      bus_req = 1'b0;
      n = 0;
      repeat (idle) tick();
      bus_req = 1'b1;
      n = 0;
      lat = -1;
      while (lat < 0 && n < 60) begin
         tick();
         if (bus_rdy) lat = n;
      end
      tick();
   endtask

   int lat;

   initial begin
      clear_marks();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R10: reset state
      chk(bus_rdy && !pd_req && !sr_req && !lite_req && !cg_ctrl && !cg_phy && !cg_dram,
          "R10 reset outputs", {pd_req, sr_req, lite_req, cg_ctrl, cg_phy, bus_rdy}, 1);

      // R3: all modes off
      configure(0, 0, 0, 0, 0, 1);
      run(80, lat);
      chk(t_pd < 0 && t_sr < 0 && t_cg < 0 && t_lt < 0 && t_sb < 0, "R3 all zero no entry", t_pd + t_sr, -2);
      chk(lat == 1 && !rdy_dropped, "R3 bus_rdy stays high", lat, 1);

      // R1 / R9: power-down threshold sweep
      for (int p = 1; p <= 12; p++) begin
         configure(p, 0, 0, 0, 0, 0);
         run(p + 6, lat);
         chk(t_pd == p + 1, "R1 pd entry edge", t_pd, p + 1);
         chk(lat == 3, "R9 pd exit latency", lat, 3);
      end

      // R1: a single busy cycle restarts the count
      configure(6, 0, 0, 0, 0, 0);
      bus_req = 1'b1; repeat (3) tick(); clear_marks();
      bus_req = 1'b0; n = 0; repeat (4) tick();
      bus_req = 1'b1; tick();
      bus_req = 1'b0; n = 0; repeat (10) tick();
      chk(t_pd == 7, "R1 count restarts after busy", t_pd, 7);
      bus_req = 1'b1; n = 0; lat = -1;
      while (lat < 0 && n < 60) begin tick(); if (bus_rdy) lat = n; end

      // R2 / R3: scaled self-refresh sweep, power-down disabled
      for (int s = 1; s <= 6; s++) begin
         configure(0, s, 0, 0, 0, 0);
         run(s * SC + 8, lat);
         chk(t_sr == s * SC + 1, "R2 sr entry edge", t_sr, s * SC + 1);
         chk(t_pd < 0, "R3 pd off when zero", t_pd, -1);
         chk(lat == 3, "R9 sr exit latency", lat, 3);
      end

      // R4: both thresholds reached together -> deepest
      configure(SC, 1, 0, 0, 0, 0);
      run(12, lat);
      chk(t_pd < 0, "R4 pd skipped", t_pd, -1);
      chk(t_sr == SC + 1, "R4 sr direct", t_sr, SC + 1);

      // R4: escalation from power-down passes through its exit
      configure(2, 2, 0, 0, 0, 0);
      run(20, lat);
      chk(t_pd == 3, "R4 pd first", t_pd, 3);
      chk(t_pdf == 9, "R4 pd exit edge", t_pdf, 9);
      chk(t_sr == 12, "R4 sr after pd exit", t_sr, 12);

      // R5: gated self-refresh sweep
      for (int c = 2; c <= 5; c++) begin
         configure(0, 1, c, 0, 0, 0);
         run(c * SC + 6, lat);
         chk(t_cg == c * SC + 1, "R5 cg_ctrl edge", t_cg, c * SC + 1);
         chk(lat == 4, "R9 gated sr exit latency", lat, 4);
      end

      // R6: lite mode with LPDDR4
      configure(0, 1, 2, 3, 0, 1);
      run(20, lat);
      chk(t_cg == 9, "R6 cg before lite", t_cg, 9);
      chk(t_lt == 3 * SC + 1, "R6 lite entry edge", t_lt, 3 * SC + 1);
      chk(lat == 7, "R9 lite exit latency", lat, 7);

      // R6: lite threshold ignored without LPDDR4
      configure(0, 1, 2, 3, 0, 0);
      run(20, lat);
      chk(t_lt < 0, "R6 lite ignored", t_lt, -1);
      chk(t_cg == 9, "R6 stays gated sr", t_cg, 9);
      chk(lat == 4, "R6 exit as gated sr", lat, 4);

      // R7: standby from self-refresh, unscaled count
      for (int k = 0; k < 3; k++) begin
         int b;
         b = 12 + k * 10;
         configure(0, 1, 0, 0, b, 0);
         run(b + 6, lat);
         chk(t_sb == b + 1, "R7 standby edge", t_sb, b + 1);
         chk(t_cg == b + 1, "R7 ctrl gated with standby", t_cg, b + 1);
         chk(lat == 4, "R9 standby exit latency", lat, 4);
      end

      // R7: standby from lite exits lite first
      configure(0, 1, 0, 3, 40, 1);
      run(50, lat);
      chk(t_lt == 13, "R7 lite reached", t_lt, 13);
      chk(t_sb == 44, "R7 standby after lite exit", t_sb, 44);
      chk(lat == 4, "R7 exit from standby", lat, 4);

      // R8: gate ordering over every scenario above
      chk(!order_bad, "R8 gates only inside acknowledged sr", order_bad, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1000000;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule